// File: doc/BRIEF.md
# Stereo Audio Sample FIFO Register Front End

This block sits between a processor register bus and the serial engine of a stereo audio port. Each of the two channels, left and right, has a transmit FIFO and a receive FIFO of 16-bit samples. Software reaches them through one data register per channel. A write to that register queues a sample for transmission, and a read takes the oldest received sample. On the serial side, the engine pulls transmit samples through a pop interface and delivers received samples through a push interface. The frame shifter and the pin timing sit outside this block.

Each channel's FIFO pair stays off until software turns it on by writing a fixed command word to a command register. Every accepted command clears a completion flag in the status register, and the flag sets again a fixed number of cycles later. Software polls this flag before it issues the next command. A global enable bit in a control register flushes every FIFO when it is written to zero.

Word address map, 3-bit `bus_addr`: 0 control (bit 0 is the global enable), 1 left data, 2 right data, 3 command, 4 status. Any other address reads zero. Read data is registered and appears on the cycle after `bus_rd`.

Top module: `audio_fifo_regs`

## Requirements
- R1: After reset the global enable and both channel enables are 0, the completion flag is 1, all FIFOs are empty and `bus_rdata` is 0. The status register then reads 0x1E1. Its layout, from bit 0 upward, is: done, left on, right on, left overflow, right overflow, left rx empty, right rx empty, left tx empty, right tx empty, left tx full, right tx full.
- R2: A data register write keeps only bits 15:0 as the sample. Every register returns zero in bits 31:16.
- R3: Transmit samples leave on `tx_data_*` in the order they were written. `tx_valid_*` is high while a sample is present, and each `tx_pop_*` removes one sample.
- R4: A data register read returns the oldest received sample of that channel and removes it.
- R5: A read of an empty receive FIFO returns zero and leaves the FIFO unchanged.
- R6: A FIFO holds 8 samples. A bus write to a full transmit FIFO is dropped and sets that channel's sticky overflow bit.
- R7: The command register compares only bits 20:0 of the written word. 0x0DC000 turns left on, 0x0D0000 turns left off, 0x11C000 turns right on and 0x110000 turns right off.
- R8: An accepted command clears the completion flag, and the flag sets again 4 cycles after the write edge. A command written while the flag is clear is ignored.
- R9: A command word that matches none of the four codes is ignored, and the completion flag stays set.
- R10: A channel that is off, or any channel while the global enable is 0, is held empty and rejects pushes from the bus and from the serial side. Its overflow bit is cleared.
- R11: Writing 0 to the global enable flushes every FIFO and clears both overflow bits, and the channel enables are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_pop_l | input | 1 | Serial side takes the left transmit sample |
| tx_data_l | output | 16 | Oldest left transmit sample |
| tx_valid_l | output | 1 | Left transmit sample present |
| tx_pop_r | input | 1 | Serial side takes the right transmit sample |
| tx_data_r | output | 16 | Oldest right transmit sample |
| tx_valid_r | output | 1 | Right transmit sample present |
| rx_push_l | input | 1 | Serial side delivers a left sample |
| rx_data_l | input | 16 | Left received sample |
| rx_push_r | input | 1 | Serial side delivers a right sample |
| rx_data_r | input | 16 | Right received sample |

## Verification
The assertions expect the bus to be single-cycle: each strobe is high for one cycle at a time, and the address is stable while it is high. They also expect the serial side to pop only while `tx_valid_*` is high. The bench drives each bus access as a one-cycle pulse, and it pops a transmit sample only after it has checked that the sample is present. The completion-latency property measures the low time of the flag with its own counter, so a command is only ever issued through the bus port.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 3;
  localparam int CMD_BITS = 21;
  localparam int NCH      = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LDATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_RDATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  localparam logic [CMD_BITS-1:0] CMD_L_ON  = 21'h0DC000;
  localparam logic [CMD_BITS-1:0] CMD_L_OFF = 21'h0D0000;
  localparam logic [CMD_BITS-1:0] CMD_R_ON  = 21'h11C000;
  localparam logic [CMD_BITS-1:0] CMD_R_OFF = 21'h110000;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import afr_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [BUS_W-1:0] word,
  output logic             done,
  output logic [NCH-1:0]   en
);
  localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [BUS_W-1:0] MASK = BUS_W'({CMD_BITS{1'b1}});

  logic [BUS_W-1:0] key;
  logic             hit_lon, hit_loff, hit_ron, hit_roff, known, accept;
  logic [CNTW-1:0]  cnt;

  always_comb begin
    key      = word & MASK;
    hit_lon  = (key == BUS_W'(CMD_L_ON));
    hit_loff = (key == BUS_W'(CMD_L_OFF));
    hit_ron  = (key == BUS_W'(CMD_R_ON));
    hit_roff = (key == BUS_W'(CMD_R_OFF));
    known    = hit_lon || hit_loff || hit_ron || hit_roff;
    accept   = wr && done && known;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b1;
      cnt  <= '0;
      en   <= '0;
    end else if (accept) begin
      done <= 1'b0;
      cnt  <= CNTW'(LAT - 1);
      if (hit_lon)  en[0] <= 1'b1;
      if (hit_loff) en[0] <= 1'b0;
      if (hit_ron)  en[1] <= 1'b1;
      if (hit_roff) en[1] <= 1'b0;
    end else if (!done) begin
      if (cnt == '0) done <= 1'b1;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/audio_channel.sv
module audio_channel #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         live,
  input  logic         bus_push,
  input  logic [W-1:0] bus_data,
  input  logic         bus_pop,
  input  logic         ser_pop,
  input  logic         ser_push,
  input  logic [W-1:0] ser_data,
  output logic [W-1:0] tx_head,
  output logic         tx_empty,
  output logic         tx_full,
  output logic [W-1:0] rx_head,
  output logic         rx_empty,
  output logic         ovf
);
  logic rx_full_unused;

  sample_fifo #(.W(W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .clr(!live),
    .push(live && bus_push), .din(bus_data),
    .pop(live && ser_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full)
  );

  sample_fifo #(.W(W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .clr(!live),
    .push(live && ser_push), .din(ser_data),
    .pop(live && bus_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full_unused)
  );

  always_ff @(posedge clk) begin
    if (rst || !live)                      ovf <= 1'b0;
    else if (bus_push && tx_full)          ovf <= 1'b1;
  end
endmodule

// File: rtl/audio_fifo_regs.sv
module audio_fifo_regs
  import afr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 8,
  parameter int DONE_LAT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                tx_pop_l,
  output logic [SAMPLE_W-1:0] tx_data_l,
  output logic                tx_valid_l,
  input  logic                tx_pop_r,
  output logic [SAMPLE_W-1:0] tx_data_r,
  output logic                tx_valid_r,
  input  logic                rx_push_l,
  input  logic [SAMPLE_W-1:0] rx_data_l,
  input  logic                rx_push_r,
  input  logic [SAMPLE_W-1:0] rx_data_r
);
  localparam int STAT_W = 3 + 4 * NCH;

  logic                glob_en;
  logic                cmd_done;
  logic [NCH-1:0]      ch_en, live;
  logic [NCH-1:0]      tx_empty, tx_full, rx_empty, ovf;
  logic [NCH-1:0]      ser_pop, ser_push, bus_push, bus_pop;
  logic [SAMPLE_W-1:0] tx_head  [NCH];
  logic [SAMPLE_W-1:0] rx_head  [NCH];
  logic [SAMPLE_W-1:0] ser_data [NCH];
  logic [STAT_W-1:0]   stat;

  assign ser_pop     = {tx_pop_r, tx_pop_l};
  assign ser_push    = {rx_push_r, rx_push_l};
  assign ser_data[0] = rx_data_l;
  assign ser_data[1] = rx_data_r;

  always_ff @(posedge clk) begin
    if (rst)                            glob_en <= 1'b0;
    else if (bus_wr && bus_addr == A_CTRL) glob_en <= bus_wdata[0];
  end

  cmd_ctrl #(.LAT(DONE_LAT)) u_cmd (
    .clk(clk), .rst(rst),
    .wr(bus_wr && bus_addr == A_CMD), .word(bus_wdata),
    .done(cmd_done), .en(ch_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] DADDR = (c == 0) ? A_LDATA : A_RDATA;
    assign live[c]     = glob_en && ch_en[c];
    assign bus_push[c] = bus_wr && bus_addr == DADDR;
    assign bus_pop[c]  = bus_rd && bus_addr == DADDR;

    audio_channel #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_chan (
      .clk(clk), .rst(rst), .live(live[c]),
      .bus_push(bus_push[c]), .bus_data(bus_wdata[SAMPLE_W-1:0]),
      .bus_pop(bus_pop[c]), .ser_pop(ser_pop[c]),
      .ser_push(ser_push[c]), .ser_data(ser_data[c]),
      .tx_head(tx_head[c]), .tx_empty(tx_empty[c]), .tx_full(tx_full[c]),
      .rx_head(rx_head[c]), .rx_empty(rx_empty[c]), .ovf(ovf[c])
    );
  end

  assign tx_data_l  = tx_head[0];
  assign tx_valid_l = !tx_empty[0];
  assign tx_data_r  = tx_head[1];
  assign tx_valid_r = !tx_empty[1];

  assign stat = {tx_full, tx_empty, rx_empty, ovf, ch_en, cmd_done};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= BUS_W'(glob_en);
        A_LDATA: bus_rdata <= rx_empty[0] ? '0 : BUS_W'(rx_head[0]);
        A_RDATA: bus_rdata <= rx_empty[1] ? '0 : BUS_W'(rx_head[1]);
        A_STAT:  bus_rdata <= BUS_W'(stat);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_fifo_regs_chk.sv
module audio_fifo_regs_chk #(
  parameter int LAT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        cmd_done,
  input logic [1:0]  ch_en,
  input logic [1:0]  live,
  input logic [1:0]  rx_empty,
  input logic        tx_valid_l,
  input logic [1:0]  ovf
);
  localparam int LW = $clog2(LAT + 2);
  localparam logic [LW-1:0] LMAX = LW'(LAT + 1);

  logic [LW-1:0] low_cnt;
  logic [20:0]   low21;
  logic          unknown;

  always_ff @(posedge clk) begin
    if (rst || cmd_done)     low_cnt <= '0;
    else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
  end

  always_comb begin
    low21   = bus_wdata[20:0];
    unknown = !(low21 == 21'h0DC000 || low21 == 21'h0D0000 ||
                low21 == 21'h11C000 || low21 == 21'h110000);
  end

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == 16'h0);

  a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd1 && rx_empty[0]) |=> bus_rdata == 32'h0);

  a_r8_done_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_done) |-> low_cnt == LW'(LAT));

  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3 && !cmd_done) |=> $stable(ch_en));

  a_r9_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3 && cmd_done && unknown) |=> (cmd_done && $stable(ch_en)));

  a_r10_off_empty: assert property (@(posedge clk) disable iff (rst)
    !live[0] |=> (rx_empty[0] && !tx_valid_l));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && live[0]) |=> ovf[0]);
endmodule

bind audio_fifo_regs audio_fifo_regs_chk #(.LAT(DONE_LAT)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cmd_done(cmd_done), .ch_en(ch_en), .live(live),
  .rx_empty(rx_empty), .tx_valid_l(tx_valid_l), .ovf(ovf)
);

// File: tb/tb_audio_fifo_regs.sv
module tb_audio_fifo_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_pop_l, tx_pop_r, tx_valid_l, tx_valid_r;
  logic [15:0] tx_data_l, tx_data_r;
  logic        rx_push_l, rx_push_r;
  logic [15:0] rx_data_l, rx_data_r;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  audio_fifo_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pop_l(tx_pop_l), .tx_data_l(tx_data_l), .tx_valid_l(tx_valid_l),
    .tx_pop_r(tx_pop_r), .tx_data_r(tx_data_r), .tx_valid_r(tx_valid_r),
    .rx_push_l(rx_push_l), .rx_data_l(rx_data_l),
    .rx_push_r(rx_push_r), .rx_data_r(rx_data_r)
  );

  localparam logic [2:0] CTRL = 3'd0, LDAT = 3'd1, RDAT = 3'd2, CMD = 3'd3, STAT = 3'd4;
  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_PL = 3'd2, K_PR = 3'd3, K_TL = 3'd4, K_TR = 3'd5;
  localparam int NV = 15;
  // kind, address, data, expected
  localparam logic [69:0] VEC [NV] = '{
    {K_WR, LDAT, 32'hABCD1111, 32'h0},
    {K_WR, LDAT, 32'h00002222, 32'h0},
    {K_WR, RDAT, 32'hFFFF3333, 32'h0},
    {K_PL, LDAT, 32'h000000A1, 32'h0},
    {K_PL, LDAT, 32'h000000A2, 32'h0},
    {K_PR, RDAT, 32'h000000B1, 32'h0},
    {K_TL, LDAT, 32'h0,        32'h00001111},
    {K_TL, LDAT, 32'h0,        32'h00002222},
    {K_TR, RDAT, 32'h0,        32'h00003333},
    {K_RD, LDAT, 32'h0,        32'h000000A1},
    {K_RD, LDAT, 32'h0,        32'h000000A2},
    {K_RD, LDAT, 32'h0,        32'h00000000},
    {K_RD, RDAT, 32'h0,        32'h000000B1},
    {K_RD, STAT, 32'h0,        32'h000001E7},
    {K_RD, CTRL, 32'h0,        32'h00000001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input bit right, input logic [15:0] d);
    @(negedge clk);
    if (right) begin rx_push_r = 1'b1; rx_data_r = d; end
    else       begin rx_push_l = 1'b1; rx_data_l = d; end
    @(negedge clk);
    rx_push_l = 1'b0; rx_push_r = 1'b0;
  endtask

  task automatic tx_take(input string req, input bit right, input logic [15:0] e);
    @(negedge clk);
    if (right) begin
      check(req, {15'h0, tx_valid_r, tx_data_r}, {15'h0, 1'b1, e});
      tx_pop_r = 1'b1;
    end else begin
      check(req, {15'h0, tx_valid_l, tx_data_l}, {15'h0, 1'b1, e});
      tx_pop_l = 1'b1;
    end
    @(negedge clk);
    tx_pop_l = 1'b0; tx_pop_r = 1'b0;
  endtask

  task automatic command(input logic [31:0] w);
    logic [31:0] s;
    bus_write(CMD, w);
    for (int i = 0; i < 20; i++) begin
      bus_read(STAT, s);
      if (s[0]) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int zeros;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_pop_l = 0; tx_pop_r = 0; rx_push_l = 0; rx_push_r = 0;
    rx_data_l = 0; rx_data_r = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(STAT, r); check("R1 status", r, 32'h1E1);
    bus_read(CTRL, r); check("R1 ctrl", r, 32'h0);
    check("R1 tx valid", {30'h0, tx_valid_r, tx_valid_l}, 32'h0);

    bus_write(CTRL, 32'h1);
    command(32'h000DC000);
    command(32'h0011C000);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  k, a;
      logic [31:0] d, e;
      {k, a, d, e} = VEC[i];
      case (k)
        K_WR: bus_write(a, d);
        K_RD: begin bus_read(a, r); check($sformatf("R2/R4 vec%0d", i), r, e); end
        K_PL: rx_push(1'b0, d[15:0]);
        K_PR: rx_push(1'b1, d[15:0]);
        K_TL: tx_take($sformatf("R3 vec%0d", i), 1'b0, e[15:0]);
        default: tx_take($sformatf("R3 vec%0d", i), 1'b1, e[15:0]);
      endcase
    end

    // R8 completion latency
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = CMD; bus_wdata = 32'h000DC000;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = STAT;
    zeros = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_rdata[0] == 1'b0) zeros++;
      else break;
    end
    bus_rd = 1'b0;
    check("R8 done latency", 32'(zeros), 32'd4);

    // R6 overflow
    for (int i = 0; i < 9; i++) bus_write(LDAT, 32'h100 + 32'(i));
    bus_read(STAT, r); check("R6 status ovf/full", r, 32'h36F);
    for (int i = 0; i < 8; i++) tx_take("R6 order", 1'b0, 16'(16'h100 + i));
    @(negedge clk); check("R6 ninth dropped", {31'h0, tx_valid_l}, 32'h0);

    // R5 empty read leaves state unchanged
    bus_read(LDAT, r); check("R5 empty read", r, 32'h0);
    rx_push(1'b0, 16'h0055);
    bus_read(LDAT, r); check("R5 after empty read", r, 32'h55);

    // R9 unknown word; R7 upper bits ignored
    bus_write(CMD, 32'h000DC001);
    bus_read(STAT, r); check("R9 unknown ignored", r & 32'h7, 32'h7);
    command(32'hFFED0000);
    bus_read(STAT, r); check("R7 21-bit decode", r, 32'h1E5);

    // R10 disabled channel
    rx_push(1'b0, 16'h0077);
    bus_write(LDAT, 32'h88);
    bus_read(LDAT, r); check("R10 rx push rejected", r, 32'h0);
    @(negedge clk); check("R10 tx push rejected", {31'h0, tx_valid_l}, 32'h0);

    // R8 busy command ignored
    bus_write(CMD, 32'h00110000);
    bus_write(CMD, 32'h000DC000);
    command(32'h0);
    bus_read(STAT, r); check("R8 busy ignored", r, 32'h1E1);

    // R11 global disable flush
    command(32'h0011C000);
    bus_write(RDAT, 32'h99);
    rx_push(1'b1, 16'h00AA);
    bus_write(CTRL, 32'h0);
    bus_read(STAT, r); check("R11 flushed", r, 32'h1E5);
    check("R11 tx gone", {31'h0, tx_valid_r}, 32'h0);
    bus_write(CTRL, 32'h1);
    bus_read(RDAT, r); check("R11 rx gone", r, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule